// File: doc/BRIEF.md
# Oversampled Data Retimer with Recovered Bit Clock

The block takes the single-bit output of a demodulator, which may carry short glitches, and turns it into a clean retimed data bit and a recovered bit clock. It runs entirely on a reference clock. A 7-bit rate setting selects the nominal bit period, which is 64 × (1 + setting) reference cycles. Each bit is oversampled at that rate.

Before its output can be trusted, the block needs an alternating 0/1 preamble. It counts transitions that land close to where a bit boundary is expected, and it reports lock once 24 such transitions have arrived in a row. After that, the recovered clock rises in the middle of every bit, and the data output is updated at exactly that moment. Every data transition re-centres the internal phase. Long runs of identical bits are therefore tolerated: without limit when the transmit and receive rates match, and for several bytes when they differ slightly.

With the enable input low, the raw input appears directly on the data output, the recovered clock stays low and lock is dropped.

Top module: `data_retimer`

## Requirements
- R1: The bit period is 64 × (1 + rate_sel) reference cycles, with rate_sel read as a 7-bit unsigned value. While no input transition occurs, two consecutive data_valid strobes are exactly one bit period apart.
- R2: A pulse on raw_in that lasts a single reference cycle has no effect. The recovered bits and the lock state are the same as without the pulse.
- R3: locked stays 0 until 24 consecutive filtered transitions have each arrived within a quarter bit period of an expected bit boundary. It rises once the 24th such transition has been seen.
- R4: locked returns to 0 in each of these cases:
  - a filtered transition arrives outside that quarter-period window;
  - rate_sel changes (locked is low from the next cycle);
  - enable is low.
- R5: After a raw_in transition, dclk_out rises and data_valid pulses between P/2+4 and P/2+10 reference cycles later, where P is the bit period. The nominal delay is P/2+7, which comes from a fixed pipeline of 7 cycles.
- R6: data_valid is high for exactly one cycle, together with each rising edge of dclk_out, and only while locked was high in the cycle before. data_out changes only on a rising edge of dclk_out and then carries the received bit. After reset, data_out, dclk_out, data_valid and locked are all 0.
- R7: A run of 200 identical bits at exactly the nominal rate is received without error. With a ±0.5 % rate offset, runs of 40 identical bits are received without error and without losing lock.
- R8: With enable low, data_out equals raw_in in the same cycle (a combinational path), and dclk_out, data_valid and locked are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | 1 = retime the input; 0 = pass raw_in straight through |
| rate_sel | input | 7 | Bit period selector; period = 64 × (1 + rate_sel) cycles |
| raw_in | input | 1 | Raw demodulator bit, asynchronous |
| data_out | output | 1 | Retimed data bit, or raw_in while bypassed |
| dclk_out | output | 1 | Recovered bit clock; rises at the centre of each bit |
| data_valid | output | 1 | One-cycle strobe on each dclk_out rise while locked |
| locked | output | 1 | Preamble acquisition complete |

## Verification
A phase counter that drifts or reloads at the wrong point shows up within one bit period as the wrong spacing between strobes, or as a strobe that is off centre relative to the last input transition. A lock counter with a wrong threshold or a wrong window shows up at the preamble checkpoints: either locked is already high after 20 bits, or it is not yet high after 32. A weak glitch filter, or a sample point in the wrong place, shows up as a mismatching bit in the scoreboard on the first affected bit. This is most visible inside 40-bit runs under a rate offset, where the sample point has drifted closest to the bit edge.

// File: rtl/rt_pkg.sv
package rt_pkg;

  // Acquisition state of the lock tracker
  typedef enum logic [0:0] {
    ACQ_HUNT  = 1'b0,
    ACQ_TRACK = 1'b1
  } acq_state_t;

  // Nominal bit period in reference cycles
  function automatic int unsigned bit_period(input int unsigned base, input int unsigned rate);
    return base * (rate + 1);
  endfunction

  // Phase at which the bit centre is sampled
  function automatic int unsigned half_period(input int unsigned p);
    return p / 2;
  endfunction

  // Width of the acceptance window on each side of a boundary
  function automatic int unsigned quarter_period(input int unsigned p);
    return p / 4;
  endfunction

  // True when a phase value lies within a quarter period of the bit boundary
  function automatic logic near_boundary(input int unsigned phase, input int unsigned p);
    return (phase >= p - quarter_period(p)) || (phase < quarter_period(p));
  endfunction

endpackage

// File: rtl/rt_glitch_filter.sv
module rt_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic level,
  output logic edge_seen
);

  localparam int VOTE_NEED = VOTE_TAPS / 2 + 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_TAPS-1:0]   hist_q;
  logic                   vote;
  logic                   level_q;
  logic                   prev_q;

  // Metastability chain, one flop per stage
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= raw_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  // Sample history for the majority vote
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= {hist_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
  end

  assign vote = ($countones(hist_q) >= VOTE_NEED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      level_q <= vote;
      prev_q  <= level_q;
    end
  end

  assign level     = level_q;
  assign edge_seen = level_q ^ prev_q;

endmodule

// File: rtl/rt_phase_gen.sv
module rt_phase_gen #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] half,
  output logic [CNT_W-1:0] phase,
  output logic             mid_hit,
  output logic             wrap_hit
);

  logic [CNT_W-1:0] phase_q;
  logic             at_last;

  assign at_last = (phase_q == period - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase_q <= '0;
    else if (!run || restart)  phase_q <= '0;
    else if (at_last)          phase_q <= '0;
    else                       phase_q <= phase_q + CNT_W'(1);
  end

  assign phase    = phase_q;
  assign mid_hit  = run && !restart && (phase_q == half);
  assign wrap_hit = run && at_last;

  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    restart || !run || (phase_q < period)); // R1

endmodule

// File: rtl/rt_lock_track.sv
module rt_lock_track #(
  parameter int RATE_W    = 7,
  parameter int CNT_W     = 14,
  parameter int LOCK_BITS = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              edge_seen,
  input  logic [CNT_W-1:0]  phase,
  input  logic [CNT_W-1:0]  period,
  output logic              rate_chg,
  output logic              locked
);

  import rt_pkg::*;

  localparam int LC_W = $clog2(LOCK_BITS + 1);

  acq_state_t        state_q;
  logic [LC_W-1:0]   good_q;
  logic [RATE_W-1:0] rate_q;
  logic              in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rate_q <= '0;
    else        rate_q <= rate_sel;
  end

  assign rate_chg = (rate_sel != rate_q);
  assign in_win   = near_boundary(32'(phase), 32'(period));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACQ_HUNT;
      good_q  <= '0;
    end else if (!enable || rate_chg) begin
      state_q <= ACQ_HUNT;
      good_q  <= '0;
    end else if (edge_seen) begin
      if (!in_win) begin
        state_q <= ACQ_HUNT;
        good_q  <= '0;
      end else if (good_q >= LC_W'(LOCK_BITS - 1)) begin
        state_q <= ACQ_TRACK;
        good_q  <= LC_W'(LOCK_BITS);
      end else begin
        good_q  <= good_q + LC_W'(1);
      end
    end
  end

  assign locked = (state_q == ACQ_TRACK);

  AST_RATE_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rate_chg |=> !locked); // R4

  AST_LOCK_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(edge_seen)); // R3

  AST_STRAY_EDGE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && !in_win) |=> !locked); // R4

endmodule

// File: rtl/data_retimer.sv
module data_retimer #(
  parameter int RATE_W      = 7,
  parameter int BASE_DIV    = 64,
  parameter int LOCK_BITS   = 24,
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              raw_in,
  output logic              data_out,
  output logic              dclk_out,
  output logic              data_valid,
  output logic              locked
);

  import rt_pkg::*;

  localparam int MAX_PERIOD = BASE_DIV * (1 << RATE_W);
  localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

  // Named internal events
  logic             filt_level;
  logic             filt_edge;
  logic             rate_chg;
  logic             restart;
  logic             mid_hit;
  logic             wrap_hit;
  logic             trk_locked;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] phase;

  logic data_q;
  logic dclk_q;
  logic valid_q;

  assign period  = CNT_W'(bit_period(BASE_DIV, 32'(rate_sel)));
  assign half    = CNT_W'(half_period(32'(period)));
  assign restart = filt_edge | rate_chg | ~enable;

  rt_glitch_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .VOTE_TAPS  (VOTE_TAPS)
  ) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (raw_in),
    .level    (filt_level),
    .edge_seen(filt_edge)
  );

  rt_phase_gen #(
    .CNT_W(CNT_W)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (enable),
    .restart (restart),
    .period  (period),
    .half    (half),
    .phase   (phase),
    .mid_hit (mid_hit),
    .wrap_hit(wrap_hit)
  );

  rt_lock_track #(
    .RATE_W   (RATE_W),
    .CNT_W    (CNT_W),
    .LOCK_BITS(LOCK_BITS)
  ) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .rate_sel (rate_sel),
    .edge_seen(filt_edge),
    .phase    (phase),
    .period   (period),
    .rate_chg (rate_chg),
    .locked   (trk_locked)
  );

  // Retiming register and recovered clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= 1'b0;
      dclk_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (!enable) begin
      dclk_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (mid_hit) begin
      data_q  <= filt_level;
      dclk_q  <= 1'b1;
      valid_q <= trk_locked;
    end else begin
      valid_q <= 1'b0;
      if (wrap_hit || restart) dclk_q <= 1'b0;
    end
  end

  assign data_out   = enable ? data_q : raw_in;
  assign dclk_out   = enable & dclk_q;
  assign data_valid = enable & valid_q;
  assign locked     = enable & trk_locked;

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid); // R6

  AST_STROBE_ON_CLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> $rose(dclk_out)); // R6

  AST_STROBE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> $past(locked)); // R6

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$rose(dclk_out)) |-> $stable(data_out)); // R6

  AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!dclk_out && !data_valid && !locked && (data_out == raw_in))); // R8

endmodule

// File: tb/tb_data_retimer.sv
module tb_data_retimer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [6:0] rate_sel = '0;
  logic       raw_in = 1'b0;
  logic       data_out, dclk_out, data_valid, locked;

  always #4 clk = ~clk;

  data_retimer dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rate_sel(rate_sel),
    .raw_in(raw_in), .data_out(data_out), .dclk_out(dclk_out),
    .data_valid(data_valid), .locked(locked)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    checks = 0;
  int    errors = 0;
  bit    exp_q[$];
  int    cur_p = 64;
  int    off_ppt = 0;
  bit    glitch_on = 0;
  int    last_chg = 0;
  int    acc = 0;
  bit    tx_val = 0;
  string cur_req = "R6";
  logic [15:0] lf = 16'hACE1;

  // Monitor state
  bit         cmp_on = 0;
  bit         prev_bit = 0;
  int         prev_valid_cyc = 0;
  logic [7:0] shreg = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  function automatic bit next_rand();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0];
  endfunction

  task automatic drive_level(input bit b, input int len, input bit glitch);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0 && raw_in != b) last_chg = cyc;
      raw_in = (glitch && i == len / 3) ? ~b : b;
    end
  endtask

  task automatic send_bit(input bit b);
    int len;
    acc += cur_p * (1000 + off_ppt);
    len = acc / 1000;
    acc -= len * 1000;
    drive_level(b, len, glitch_on && len >= 30);
    tx_val = b;
  endtask

  task automatic send_alt(input int n);
    for (int i = 0; i < n; i++) send_bit(~tx_val);
  endtask

  // Driver: queue the expected payload, then send marker, payload and padding
  task automatic run_payload(input string req, input int n1, input int runlen,
                             input bit runv, input int n2);
    bit pl[$];
    cur_req = req;
    for (int i = 0; i < n1; i++) pl.push_back(next_rand());
    for (int i = 0; i < runlen; i++) pl.push_back(runv);
    for (int i = 0; i < n2; i++) pl.push_back(next_rand());
    foreach (pl[i]) exp_q.push_back(pl[i]);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    foreach (pl[i]) send_bit(pl[i]);
    send_alt(8);
    check(exp_q.size() == 0, "R6", "payload bits left unreceived", exp_q.size(), 0);
  endtask

  // Monitor: pops expected bits as strobes arrive
  always @(negedge clk) begin
    if (rst_n && data_valid) begin
      if (cmp_on) begin
        bit e;
        e = exp_q.pop_front();
        check(data_out == e, cur_req, "retimed bit", data_out, e);
        if (prev_bit == data_out && off_ppt == 0)
          check(cyc - prev_valid_cyc == cur_p, "R1", "strobe spacing in a run",
                cyc - prev_valid_cyc, cur_p);
        if (prev_bit != data_out)
          check((cyc - last_chg >= cur_p / 2 + 4) && (cyc - last_chg <= cur_p / 2 + 10),
                "R5", "strobe delay after transition", cyc - last_chg, cur_p / 2 + 7);
        prev_bit = data_out;
        if (exp_q.size() == 0) cmp_on = 0;
      end else begin
        shreg = {shreg[6:0], data_out};
        if (shreg == 8'hF0 && exp_q.size() > 0) begin
          cmp_on   = 1;
          prev_bit = 0;
        end
      end
      prev_valid_cyc = cyc;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(data_out == 0 && dclk_out == 0 && data_valid == 0 && locked == 0,
          "R6", "outputs during reset", {data_out, dclk_out, data_valid, locked}, 0);
    rst_n = 1'b1;

    // Bypass
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      raw_in = i[0];
      #1;
      check(data_out == raw_in, "R8", "bypass data", data_out, raw_in);
      check(dclk_out == 0 && locked == 0, "R8", "bypass clock/lock", {dclk_out, locked}, 0);
    end
    tx_val = raw_in;
    send_alt(30);
    check(locked == 0, "R8", "lock while bypassed", locked, 0);

    // Acquisition and an unlimited run at exact rate
    @(negedge clk);
    enable = 1'b1;
    acc = 0;
    send_alt(20);
    check(locked == 0, "R3", "lock after 20 preamble bits", locked, 0);
    send_alt(12);
    check(locked == 1, "R3", "lock after 32 preamble bits", locked, 1);
    run_payload("R7", 16, 200, 1'b1, 16);

    // +0.5% offset with single-cycle glitches
    off_ppt = 5;
    glitch_on = 1;
    send_alt(32);
    check(locked == 1, "R3", "lock with fast sender", locked, 1);
    run_payload("R2", 30, 40, 1'b0, 20);
    run_payload("R7", 10, 40, 1'b1, 10);

    // -0.5% offset
    off_ppt = -5;
    send_alt(32);
    run_payload("R2", 20, 40, 1'b1, 20);
    check(locked == 1, "R2", "lock kept despite glitches", locked, 1);
    glitch_on = 0;
    off_ppt = 0;

    // Out-of-window transition
    send_alt(4);
    drive_level(~tx_val, cur_p / 2, 1'b0);
    tx_val = ~tx_val;
    drive_level(~tx_val, 12, 1'b0);
    tx_val = ~tx_val;
    check(locked == 0, "R4", "lock after stray transition", locked, 0);
    drive_level(tx_val, cur_p - 12, 1'b0);
    acc = 0;
    send_alt(32);
    check(locked == 1, "R3", "relock after stray transition", locked, 1);

    // Rate change
    @(negedge clk);
    rate_sel = 7'd1;
    repeat (2) @(negedge clk);
    check(locked == 0, "R4", "lock after rate change", locked, 0);
    cur_p = 64 * (1 + 1);
    acc = 0;
    send_alt(32);
    check(locked == 1, "R3", "lock at slower rate", locked, 1);
    run_payload("R1", 10, 12, 1'b0, 10);

    // Disable
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check(locked == 0 && dclk_out == 0, "R4", "lock/clock after disable", {locked, dclk_out}, 0);
    raw_in = ~raw_in;
    #1;
    check(data_out == raw_in, "R8", "bypass after disable", data_out, raw_in);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule